// File: doc/BRIEF.md
# DMA Channel Request and Arbitration Unit

This unit is the control core of a four-channel DMA controller. Each channel is triggered from one of three sources: an automatic internal request that is always present, a request line from an on-chip peripheral, or an active-low external pin. External pins exist on channels 0 and 1 only. Each pin is sensed either on a falling edge, which is latched, or on a low level. The unit picks one eligible channel under fixed or rotating priority. It then presents a grant, the channel number and that channel's working source address to an external bus engine. The bus engine answers with a one-cycle completion pulse for each transfer.

Per channel, the unit holds an enable, a transfer count, a working source address and a mode set. A channel in cycle-steal mode gives up the grant after every transfer. A channel in burst mode keeps the grant until its count runs out. When a count reaches zero, the channel disables itself and sets its end flag. If the interrupt is enabled, that flag drives the channel's interrupt line until software clears it. Channel 2 can restore its programmed source address after every fourth transfer. A global abort input blocks all new grants.

Software writes configuration through a simple write port. Field `cfg_sel` picks the target: 0 is the control word, 1 is the transfer count, 2 is the source address, and 3 has no effect. The control word has these fields:
- bit 0: enable
- bits 2:1: trigger (00 auto, 01 peripheral, 10 external pin, 11 none)
- bit 3: level sensing (1) or falling-edge sensing (0)
- bit 4: burst (1) or cycle-steal (0)
- bit 5: interrupt enable
- bit 6: reload enable, which acts on channel 2 only
- bit 7: write 1 to clear the end flag

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant and all interrupt lines are low, and no channel is enabled.
- R2: An enabled auto-triggered channel with a non-zero count is granted. Each completion pulse decrements its count and advances its working source address by INC (default 4), and grant_src shows the address of the current transfer.
- R3: A channel whose trigger is 01 is granted only while its bit of periph_req is high.
- R4: A trigger of 10 works on channels 0 and 1 only. With edge sensing, each falling edge of the pin yields exactly one transfer, and the latched edge is cleared when that transfer is granted. With level sensing, the pin is sampled again after each transfer. Channels 2 and 3 set to trigger 10 are never granted.
- R5: In cycle-steal mode, grant is low in the cycle after each completion pulse.
- R6: In burst mode, grant stays high on the same channel from the first transfer until the count is exhausted.
- R7: When rr_mode is low, priority is fixed: channel 0 highest, channel 3 lowest.
- R8: When rr_mode is high, the accepted channel becomes lowest priority, so the next search starts at the following channel. After reset the search starts at channel 0.
- R9: When the count reaches zero, the channel's enable clears and its end flag sets. irq is the flag ANDed with the interrupt enable. The flag holds until a control write with bit 7 set.
- R10: When channel 2 has reload enabled, its working source address returns to the last programmed source address after every fourth transfer.
- R11: No channel is granted while abort is high, while its enable is clear, or while its count is zero. Clearing the enable or raising abort during a burst ends that burst at the next completion.
- R12: Between completion pulses, grant and grant_ch stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Target: 0 control, 1 count, 2 source address, 3 none |
| cfg_wdata | input | AW | Write data |
| rr_mode | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| abort | input | 1 | Blocks new grants and ends bursts |
| ext_req_n | input | 2 | Active-low external request pins for channels 0 and 1 |
| periph_req | input | 4 | Peripheral request line for each channel |
| xfer_done | input | 1 | One-cycle completion pulse from the bus engine |
| grant | output | 1 | Transfer granted to the bus engine |
| grant_ch | output | 2 | Granted channel |
| grant_src | output | AW | Working source address of the granted channel |
| irq | output | 4 | End-of-transfer interrupt for each channel |

## Verification
The assertions check on every cycle that:
- a granted channel never has a zero count;
- the grant and channel do not change before a completion;
- cycle-steal releases the bus after each completion;
- an eligible burst keeps the bus;
- abort prevents any new grant;
- the final completion disables the channel and sets its flag.

Some behaviours appear only over a sequence of events, so the bench scenarios show them:
- the order of grants under both priority schemes;
- one transfer per falling edge versus repeated transfers on a held level;
- the address step and its reload on every fourth transfer;
- the interrupt flag staying set until its clear write.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int INC = 4,
  parameter int RELOAD_EVERY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_ch,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rr_mode,
  input  logic          abort,
  input  logic [1:0]    ext_req_n,
  input  logic [3:0]    periph_req,
  input  logic          xfer_done,
  output logic          grant,
  output logic [1:0]    grant_ch,
  output logic [AW-1:0] grant_src,
  output logic [3:0]    irq
);
  localparam int NCH = 4;
  localparam int RLW = $clog2(RELOAD_EVERY + 1);
  localparam logic [RLW-1:0] RL_LAST = RLW'(RELOAD_EVERY - 1);
  localparam logic [1:0] RL_CH = 2'd2;

  logic [NCH-1:0] en_q, lvl_q, burst_q, ie_q, flag_q;
  logic [1:0]     trig_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [AW-1:0]  work_q [NCH];
  logic [AW-1:0]  prog_q;
  logic           rl_en_q;
  logic [RLW-1:0] rl_cnt_q;
  logic [1:0]     ext_prev_n, edge_pend;
  logic           busy_q;
  logic [1:0]     act_q, rr_top_q;

  logic [NCH-1:0] req, elig;
  logic [1:0]     pick, top;
  logic           pick_v, start, fin, last, stay;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      case (trig_q[c])
        2'd0: req[c] = 1'b1;
        2'd1: req[c] = periph_req[c];
        2'd2: req[c] = (c < 2) ? (lvl_q[c] ? ~ext_req_n[c % 2] : edge_pend[c % 2]) : 1'b0;
        default: req[c] = 1'b0;
      endcase
      elig[c] = en_q[c] && (cnt_q[c] != '0) && req[c] && !abort;
    end
  end

  assign top = rr_mode ? rr_top_q : 2'd0;

  always_comb begin
    pick = 2'd0;
    pick_v = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      logic [1:0] idx;
      idx = top + 2'(i);
      if (!pick_v && elig[idx]) begin
        pick = idx;
        pick_v = 1'b1;
      end
    end
  end

  assign start = !busy_q && pick_v;
  assign fin   = busy_q && xfer_done;
  assign last  = fin && (cnt_q[act_q] == CW'(1));
  assign stay  = fin && !last && burst_q[act_q] && en_q[act_q] && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; lvl_q <= '0; burst_q <= '0; ie_q <= '0; flag_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        trig_q[c] <= 2'd3;
        cnt_q[c]  <= '0;
        work_q[c] <= '0;
      end
      prog_q <= '0; rl_en_q <= 1'b0; rl_cnt_q <= '0;
      ext_prev_n <= 2'b11; edge_pend <= 2'b00;
      busy_q <= 1'b0; act_q <= 2'd0; rr_top_q <= 2'd0;
    end else begin
      ext_prev_n <= ext_req_n;
      for (int c = 0; c < 2; c++) begin
        if (ext_prev_n[c] && !ext_req_n[c] && en_q[c] && trig_q[c] == 2'd2 && !lvl_q[c])
          edge_pend[c] <= 1'b1;
        if (start && pick == 2'(c))
          edge_pend[c] <= 1'b0;
      end

      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            en_q[cfg_ch]    <= cfg_wdata[0];
            trig_q[cfg_ch]  <= cfg_wdata[2:1];
            lvl_q[cfg_ch]   <= cfg_wdata[3];
            burst_q[cfg_ch] <= cfg_wdata[4];
            ie_q[cfg_ch]    <= cfg_wdata[5];
            if (cfg_ch == RL_CH) rl_en_q <= cfg_wdata[6];
            if (cfg_wdata[7]) flag_q[cfg_ch] <= 1'b0;
          end
          2'd1: cnt_q[cfg_ch] <= cfg_wdata[CW-1:0];
          2'd2: begin
            work_q[cfg_ch] <= cfg_wdata;
            if (cfg_ch == RL_CH) begin
              prog_q   <= cfg_wdata;
              rl_cnt_q <= '0;
            end
          end
          default: ;
        endcase
      end

      if (start) begin
        busy_q <= 1'b1;
        act_q  <= pick;
        if (rr_mode) rr_top_q <= pick + 2'd1;
      end

      if (fin) begin
        cnt_q[act_q] <= cnt_q[act_q] - CW'(1);
        if (act_q == RL_CH && rl_en_q && rl_cnt_q == RL_LAST) begin
          work_q[act_q] <= prog_q;
          rl_cnt_q <= '0;
        end else begin
          work_q[act_q] <= work_q[act_q] + AW'(INC);
          if (act_q == RL_CH && rl_en_q) rl_cnt_q <= rl_cnt_q + RLW'(1);
        end
        if (last) begin
          en_q[act_q]   <= 1'b0;
          flag_q[act_q] <= 1'b1;
        end
        busy_q <= stay;
      end
    end
  end

  assign grant     = busy_q;
  assign grant_ch  = act_q;
  assign grant_src = work_q[act_q];
  assign irq       = flag_q & ie_q;

  assert_grant_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> cnt_q[grant_ch] != '0);

  assert_steal_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && xfer_done && !burst_q[grant_ch]) |=> !grant);

  assert_burst_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && xfer_done && burst_q[grant_ch] && en_q[grant_ch] && !abort
     && cnt_q[grant_ch] != CW'(1)) |=> (grant && $stable(grant_ch)));

  assert_last_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && xfer_done && cnt_q[grant_ch] == CW'(1))
      |=> (!grant && !en_q[$past(grant_ch)] && flag_q[$past(grant_ch)]));

  assert_abort_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !grant) |=> !grant);

  assert_hold_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !xfer_done) |=> (grant && $stable(grant_ch)));
endmodule

// File: tb/dma_chan_arbiter_test.sv
module dma_chan_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n, cfg_we, rr_mode, abort, xfer_done;
  logic [1:0]  cfg_ch, cfg_sel, ext_req_n, grant_ch;
  logic [31:0] cfg_wdata, grant_src;
  logic [3:0]  periph_req, irq;
  logic        grant;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dma_chan_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rr_mode(rr_mode), .abort(abort), .ext_req_n(ext_req_n),
    .periph_req(periph_req), .xfer_done(xfer_done), .grant(grant), .grant_ch(grant_ch),
    .grant_src(grant_src), .irq(irq)
  );

  // peripheral request mask, expected channel under fixed priority (R7)
  localparam logic [5:0] VEC [8] = '{
    {4'b1111, 2'd0}, {4'b1110, 2'd1}, {4'b1100, 2'd2}, {4'b1000, 2'd3},
    {4'b1010, 2'd1}, {4'b0101, 2'd0}, {4'b0110, 2'd1}, {4'b1001, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = 2'd0; cfg_sel = 2'd0; cfg_wdata = '0;
    rr_mode = 1'b0; abort = 1'b0; xfer_done = 1'b0; ext_req_n = 2'b11; periph_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic done_pulse();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic wait_grant(input int n);
    for (int k = 0; k < n && !grant; k++) @(negedge clk);
  endtask

  task automatic idle_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!grant, tag, {31'd0, grant}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk(!grant, "R1 grant after reset", {31'd0, grant}, 0);
    chk(irq == 4'd0, "R1 irq after reset", {28'd0, irq}, 0);
    wr(2'd0, 2'd1, 32'd5);
    idle_check(3, "R1 channel disabled after reset");

    // R7 / R3 fixed priority with peripheral triggers
    do_reset();
    for (int c = 0; c < 4; c++) begin
      wr(2'(c), 2'd1, 32'd50);
      wr(2'(c), 2'd0, 32'h03);
    end
    idle_check(2, "R3 no request line no grant");
    for (int v = 0; v < 8; v++) begin
      periph_req = VEC[v][5:2];
      wait_grant(4);
      chk(grant && grant_ch == VEC[v][1:0], "R7 fixed priority", {30'd0, grant_ch}, {30'd0, VEC[v][1:0]});
      periph_req = '0;
      done_pulse();
      chk(!grant, "R5 cycle-steal release", {31'd0, grant}, 0);
    end

    // R8 rotating priority
    do_reset();
    rr_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      wr(2'(c), 2'd1, 32'd50);
      wr(2'(c), 2'd0, 32'h03);
    end
    periph_req = 4'hF;
    for (int i = 0; i < 6; i++) begin
      wait_grant(4);
      chk(grant && grant_ch == 2'(i % 4), "R8 rotation all requesting", {30'd0, grant_ch}, i % 4);
      done_pulse();
    end
    periph_req = 4'b0101;
    for (int i = 0; i < 3; i++) begin
      wait_grant(4);
      chk(grant && grant_ch == ((i % 2 == 0) ? 2'd2 : 2'd0), "R8 rotation partial",
          {30'd0, grant_ch}, (i % 2 == 0) ? 2 : 0);
      done_pulse();
    end
    periph_req = '0;

    // R2 / R9 auto trigger, count and address step
    do_reset();
    wr(2'd1, 2'd2, 32'h100);
    wr(2'd1, 2'd1, 32'd3);
    wr(2'd1, 2'd0, 32'h01);
    for (int i = 0; i < 3; i++) begin
      wait_grant(4);
      chk(grant && grant_ch == 2'd1 && grant_src == 32'h100 + 32'(4 * i), "R2 auto transfer address",
          grant_src, 32'h100 + 32'(4 * i));
      done_pulse();
      chk(!grant, "R5 release after transfer", {31'd0, grant}, 0);
    end
    idle_check(3, "R2 stop at zero count");
    chk(irq == 4'd0, "R9 irq masked when disabled", {28'd0, irq}, 0);
    wr(2'd1, 2'd1, 32'd2);
    idle_check(3, "R9 enable cleared at zero count");

    // R6 / R9 burst and interrupt flag
    do_reset();
    wr(2'd3, 2'd2, 32'h40);
    wr(2'd3, 2'd1, 32'd3);
    wr(2'd3, 2'd0, 32'h31);
    wait_grant(4);
    for (int i = 0; i < 3; i++) begin
      chk(grant && grant_ch == 2'd3 && grant_src == 32'h40 + 32'(4 * i), "R6 burst continuous",
          grant_src, 32'h40 + 32'(4 * i));
      done_pulse();
    end
    chk(!grant, "R6 burst ends at zero", {31'd0, grant}, 0);
    chk(irq == 4'b1000, "R9 irq raised", {28'd0, irq}, 32'h8);
    repeat (5) @(negedge clk);
    chk(irq == 4'b1000, "R9 irq held", {28'd0, irq}, 32'h8);
    wr(2'd3, 2'd0, 32'hA0);
    chk(irq == 4'b0000, "R9 irq cleared by write", {28'd0, irq}, 0);

    // R10 reload on channel 2
    do_reset();
    wr(2'd2, 2'd2, 32'h200);
    wr(2'd2, 2'd1, 32'd9);
    wr(2'd2, 2'd0, 32'h51);
    wait_grant(4);
    for (int i = 0; i < 9; i++) begin
      chk(grant && grant_src == 32'h200 + 32'(4 * (i % 4)), "R10 reload sequence",
          grant_src, 32'h200 + 32'(4 * (i % 4)));
      done_pulse();
    end

    // R4 external falling edge on channel 0
    do_reset();
    wr(2'd0, 2'd1, 32'd10);
    wr(2'd0, 2'd0, 32'h05);
    idle_check(3, "R4 no edge no grant");
    ext_req_n[0] = 1'b0;
    wait_grant(4);
    chk(grant && grant_ch == 2'd0, "R4 edge granted", {30'd0, grant_ch}, 0);
    done_pulse();
    idle_check(4, "R4 one transfer per edge");
    ext_req_n[0] = 1'b1;
    @(negedge clk);
    ext_req_n[0] = 1'b0;
    wait_grant(4);
    chk(grant && grant_ch == 2'd0, "R4 second edge granted", {30'd0, grant_ch}, 0);
    done_pulse();
    ext_req_n[0] = 1'b1;

    // R4 external level on channel 1
    wr(2'd1, 2'd1, 32'd10);
    wr(2'd1, 2'd0, 32'h0D);
    ext_req_n[1] = 1'b0;
    wait_grant(4);
    chk(grant && grant_ch == 2'd1, "R4 level granted", {30'd0, grant_ch}, 1);
    done_pulse();
    wait_grant(4);
    chk(grant && grant_ch == 2'd1, "R4 level resampled", {30'd0, grant_ch}, 1);
    ext_req_n[1] = 1'b1;
    done_pulse();
    idle_check(3, "R4 level released");

    // R4 channel 2 has no external pin
    do_reset();
    wr(2'd2, 2'd1, 32'd5);
    wr(2'd2, 2'd0, 32'h05);
    ext_req_n = 2'b00;
    idle_check(4, "R4 channel 2 external ignored");

    // R11 abort, zero count, mid-burst disable
    do_reset();
    abort = 1'b1;
    wr(2'd0, 2'd1, 32'd5);
    wr(2'd0, 2'd0, 32'h01);
    idle_check(3, "R11 abort blocks grant");
    abort = 1'b0;
    wait_grant(4);
    chk(grant, "R11 grant after abort release", {31'd0, grant}, 1);

    do_reset();
    wr(2'd1, 2'd0, 32'h01);
    idle_check(3, "R11 zero count not eligible");

    do_reset();
    wr(2'd0, 2'd1, 32'd10);
    wr(2'd0, 2'd0, 32'h11);
    wait_grant(4);
    done_pulse();
    chk(grant && grant_ch == 2'd0, "R6 burst still held", {31'd0, grant}, 1);
    wr(2'd0, 2'd0, 32'h10);
    repeat (4) @(negedge clk);
    chk(grant && grant_ch == 2'd0, "R12 grant stable without completion", {31'd0, grant}, 1);
    done_pulse();
    chk(!grant, "R11 disable ends burst", {31'd0, grant}, 0);
    idle_check(3, "R11 disabled stays idle");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule